// File: doc/BRIEF.md
# Requester-to-Stream ID Translation Table

This block maps the 16-bit requester ID carried by an incoming PCIe transaction onto a 6-bit stream ID. The stream ID is consumed downstream by address-translation and interrupt logic. The table holds a parameterised number of entries (32 by default). Each entry carries a valid flag, a reference requester ID, a 16-bit compare mask, a stream ID and a 3-bit ID tag. A lookup compares the presented requester ID with every valid entry at once, counting only the bits the entry's mask selects. The lowest-numbered matching entry supplies the answer.

Software never touches an entry directly. It fills two staging registers, then writes the control register with a direction bit and an entry index. With the direction bit clear, the write copies the staging contents into the entry. With it set, the write copies the entry into the staging registers, where software can read it back. Clearing both staging registers and committing them releases an entry.

The lookup side is a valid/ready stream with a one-deep registered result. A request is taken when `lk_valid` and `lk_ready` are both high. Its result appears on the next cycle and stays in place until `res_ready` accepts it. `lk_ready` falls while an unaccepted result is held, so back-pressure from the result side stalls the request side without losing data. For interrupt use, the result is also given as an 8-bit value: this instance's 2-bit controller code (a parameter taking the values 00, 01 or 10) placed above the stream ID.

Top module: `rid_sid_xlate`

## Requirements
- R1: Register address 0 is the control register. Bits 4:0 select the entry and bit 16 is the direction. A read returns the last written index and direction bit, and every other bit reads zero.
- R2: Writing the control register with bit 16 set loads the indexed entry into the staging registers. The valid flag, tag, stream ID, requester ID and mask are then readable at addresses 1 and 2.
- R3: Writing the control register with bit 16 clear commits the staging registers into the indexed entry. A lookup accepted in the same cycle as that write sees the old contents. A lookup accepted on any later cycle sees the new contents.
- R4: Address 1 holds the valid flag in bit 31, the tag in bits 10:8 and the stream ID in bits 5:0. Address 2 holds the requester ID in bits 31:16 and the mask in bits 15:0. Unassigned bits of address 1 read zero, address 3 reads zero, and writes to address 3 are ignored.
- R5: An entry matches when its valid flag is set and the lookup ID equals its requester ID on every bit whose mask bit is 1. An all-ones mask therefore needs an exact match, and an invalid entry never matches. On a miss, `res_hit` is 0 and `res_sid` and `res_tag` are 0.
- R6: When several valid entries match, the result comes from the lowest-numbered one.
- R7: `res_msi_id` equals the controller-code parameter in bits 7:6, with `res_sid` in bits 5:0.
- R8: A request is accepted when `lk_valid` and `lk_ready` are both high, and its result is valid on the following cycle. `lk_ready` is low only while a result is valid and `res_ready` is low. While that stall lasts, all result outputs hold steady.
- R9: An active-low synchronous reset clears every entry, both staging registers, the control register, the read data and the result-valid flag.
- R10: A register read returns data one cycle after `csr_rd_en` and holds it until the next read. Addresses 1 and 2 return the staging contents, not the live table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register word address |
| csr_wdata | input | 32 | Register write data |
| csr_rd_en | input | 1 | Register read strobe |
| csr_rdata | output | 32 | Register read data, one cycle after the strobe |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready |
| lk_rid | input | 16 | Requester ID to translate |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted by consumer |
| res_hit | output | 1 | An entry matched |
| res_sid | output | 6 | Stream ID of the winning entry |
| res_tag | output | 3 | ID tag of the winning entry |
| res_msi_id | output | 8 | Controller code above stream ID |

## Verification
The bench builds the block with the full 32 entries, so index 31 and the highest-numbered compare lane are exercised. It sets the controller code to 10, which makes the prefix in `res_msi_id` distinguishable from a zero default. A catch-all entry (mask zero) placed at a low index exercises priority against exact and partially masked entries at higher indices. Random toggling of `res_ready` exercises the stall path under a stream of mixed hits and misses.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
  localparam int RID_W     = 16;
  localparam int SID_W     = 6;
  localparam int TAG_W     = 3;
  localparam int CSR_W     = 32;
  localparam int CSR_AW    = 2;
  localparam int IDX_FLD_W = 5;
  localparam int DIR_BIT   = 16;
  localparam int VLD_BIT   = 31;
  localparam int TAG_LSB   = 8;
  localparam int RID_LSB   = 16;
  localparam int CID_W     = 2;

  typedef enum logic [CSR_AW-1:0] {
    A_CTRL = 2'd0,
    A_ATTR = 2'd1,
    A_KEY  = 2'd2,
    A_NONE = 2'd3
  } rsx_addr_e;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [SID_W-1:0] sid;
    logic [RID_W-1:0] rid;
    logic [RID_W-1:0] mask;
  } rsx_entry_t;
endpackage

// File: rtl/rsx_regs.sv
module rsx_regs
  import rsx_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CSR_AW-1:0]    addr,
  input  logic [CSR_W-1:0]     wdata,
  input  logic                 rd_en,
  output logic [CSR_W-1:0]     rd_data,
  input  rsx_entry_t           fetch_ent,
  output logic [IDX_FLD_W-1:0] acc_idx,
  output logic                 fetch_stb,
  output logic                 commit_stb,
  output rsx_entry_t           stage
);
  logic                 ctl_dir;
  logic [IDX_FLD_W-1:0] ctl_idx;
  logic                 wr_ctl;
  logic                 idx_ok;
  logic [CSR_W-1:0]     rd_next;
  logic                 unused_wbits;

  assign acc_idx    = wdata[IDX_FLD_W-1:0];
  assign wr_ctl     = wr_en && (addr == A_CTRL);
  assign idx_ok     = int'(acc_idx) < ENTRIES;
  assign fetch_stb  = wr_ctl && wdata[DIR_BIT] && idx_ok;
  assign commit_stb = wr_ctl && !wdata[DIR_BIT] && idx_ok;
  assign unused_wbits = ^{wdata[30:17], wdata[15:11], wdata[7:6]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_dir <= 1'b0;
      ctl_idx <= '0;
      stage   <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_dir <= wdata[DIR_BIT];
        ctl_idx <= acc_idx;
      end
      if (fetch_stb) begin
        stage <= fetch_ent;
      end else if (wr_en && addr == A_ATTR) begin
        stage.vld <= wdata[VLD_BIT];
        stage.tag <= wdata[TAG_LSB +: TAG_W];
        stage.sid <= wdata[SID_W-1:0];
      end else if (wr_en && addr == A_KEY) begin
        stage.rid  <= wdata[RID_LSB +: RID_W];
        stage.mask <= wdata[RID_W-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    unique case (addr)
      A_CTRL: begin
        rd_next[DIR_BIT]             = ctl_dir;
        rd_next[IDX_FLD_W-1:0]       = ctl_idx;
      end
      A_ATTR: begin
        rd_next[VLD_BIT]             = stage.vld;
        rd_next[TAG_LSB +: TAG_W]    = stage.tag;
        rd_next[SID_W-1:0]           = stage.sid;
      end
      A_KEY: begin
        rd_next[RID_LSB +: RID_W]    = stage.rid;
        rd_next[RID_W-1:0]           = stage.mask;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  // R10: the read data only changes in the cycle after a read strobe
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/rsx_table.sv
module rsx_table
  import rsx_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_FLD_W-1:0] widx,
  input  rsx_entry_t           wdat,
  input  logic [IDX_FLD_W-1:0] ridx,
  output rsx_entry_t           rdat,
  output rsx_entry_t           ents [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                               ents[g] <= '0;
      else if (we && int'(widx) == g)           ents[g] <= wdat;
    end
  end

  always_comb begin
    rdat = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (int'(ridx) == i) rdat = ents[i];
    end
  end
endmodule

// File: rtl/rsx_match.sv
module rsx_match
  import rsx_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rsx_entry_t       ents [ENTRIES],
  input  logic             req_valid,
  input  logic [RID_W-1:0] req_rid,
  output logic             req_ready,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [SID_W-1:0] rsp_sid,
  output logic [TAG_W-1:0] rsp_tag
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] hv;
  logic [IDX_W-1:0]   sel;
  logic               any;
  logic               take;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hv[g] = ents[g].vld &&
                   (((req_rid ^ ents[g].rid) & ents[g].mask) == '0);
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hv[i]) sel = IDX_W'(i);
    end
  end

  assign any       = |hv;
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_sid   <= '0;
      rsp_tag   <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= any;
      rsp_sid   <= any ? ents[sel].sid : '0;
      rsp_tag   <= any ? ents[sel].tag : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: an accepted request yields a valid result next cycle
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R8: stalled result holds steady
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) &&
                                   $stable(rsp_sid) && $stable(rsp_tag)));
  // R5: a miss carries zero stream ID and tag
  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_sid == '0 && rsp_tag == '0));
endmodule

// File: rtl/rid_sid_xlate.sv
module rid_sid_xlate
  import rsx_pkg::*;
#(
  parameter int                ENTRIES = 32,
  parameter logic [CID_W-1:0]  CTRL_ID = 2'b00
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      csr_wr_en,
  input  logic [CSR_AW-1:0]         csr_addr,
  input  logic [CSR_W-1:0]          csr_wdata,
  input  logic                      csr_rd_en,
  output logic [CSR_W-1:0]          csr_rdata,
  input  logic                      lk_valid,
  output logic                      lk_ready,
  input  logic [RID_W-1:0]          lk_rid,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic                      res_hit,
  output logic [SID_W-1:0]          res_sid,
  output logic [TAG_W-1:0]          res_tag,
  output logic [CID_W+SID_W-1:0]    res_msi_id
);
  rsx_entry_t           stage;
  rsx_entry_t           fetch_ent;
  rsx_entry_t           ents [ENTRIES];
  logic [IDX_FLD_W-1:0] acc_idx;
  logic                 fetch_stb;
  logic                 commit_stb;

  rsx_regs #(.ENTRIES(ENTRIES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (csr_wr_en),
    .addr       (csr_addr),
    .wdata      (csr_wdata),
    .rd_en      (csr_rd_en),
    .rd_data    (csr_rdata),
    .fetch_ent  (fetch_ent),
    .acc_idx    (acc_idx),
    .fetch_stb  (fetch_stb),
    .commit_stb (commit_stb),
    .stage      (stage)
  );

  rsx_table #(.ENTRIES(ENTRIES)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit_stb),
    .widx  (acc_idx),
    .wdat  (stage),
    .ridx  (acc_idx),
    .rdat  (fetch_ent),
    .ents  (ents)
  );

  rsx_match #(.ENTRIES(ENTRIES)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .ents      (ents),
    .req_valid (lk_valid),
    .req_rid   (lk_rid),
    .req_ready (lk_ready),
    .rsp_ready (res_ready),
    .rsp_valid (res_valid),
    .rsp_hit   (res_hit),
    .rsp_sid   (res_sid),
    .rsp_tag   (res_tag)
  );

  assign res_msi_id = {CTRL_ID, res_sid};

  // R3: a commit lands the staged contents in the indexed entry
  a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> (ents[$past(acc_idx)] == $past(stage)));
  // R2: a fetch lands the indexed entry in the staging registers
  a_r2_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |=> (stage == $past(ents[acc_idx])));
endmodule

// File: tb/test_rid_sid_xlate.sv
module test_rid_sid_xlate;
  localparam int         CLK_PERIOD = 10;
  localparam int         N          = 32;
  localparam logic [1:0] CID        = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0, csr_rd_en = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic        lk_valid = 1'b0, lk_ready;
  logic [15:0] lk_rid = '0;
  logic        res_valid, res_ready = 1'b1, res_hit;
  logic [5:0]  res_sid;
  logic [2:0]  res_tag;
  logic [7:0]  res_msi_id;

  int checks = 0, fails = 0;
  bit live = 1'b0;

  rid_sid_xlate #(.ENTRIES(N), .CTRL_ID(CID)) i_rid_sid_xlate (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rd_en(csr_rd_en), .csr_rdata(csr_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_rid(lk_rid),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_sid(res_sid), .res_tag(res_tag), .res_msi_id(res_msi_id));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic        m_vld [N];
  logic [2:0]  m_tag [N];
  logic [5:0]  m_sid [N];
  logic [15:0] m_rid [N];
  logic [15:0] m_msk [N];
  logic        s_vld; logic [2:0] s_tag; logic [5:0] s_sid;
  logic [15:0] s_rid, s_msk;
  logic        m_dir; logic [4:0] m_idx;
  logic [31:0] m_rd;
  logic        m_rv, m_hit; logic [5:0] m_osid; logic [2:0] m_otag;

  function automatic int find(logic [15:0] rid);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && (((rid ^ m_rid[i]) & m_msk[i]) == 16'h0)) return i;
    return -1;
  endfunction

  function automatic logic [31:0] reg_val(logic [1:0] a);
    case (a)
      2'd0:    return {15'h0, m_dir, 11'h0, m_idx};
      2'd1:    return {s_vld, 20'h0, s_tag, 2'b00, s_sid};
      2'd2:    return {s_rid, s_msk};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vld[i] <= 1'b0; m_tag[i] <= '0; m_sid[i] <= '0; m_rid[i] <= '0; m_msk[i] <= '0;
      end
      s_vld <= 1'b0; s_tag <= '0; s_sid <= '0; s_rid <= '0; s_msk <= '0;
      m_dir <= 1'b0; m_idx <= '0; m_rd <= '0;
      m_rv <= 1'b0; m_hit <= 1'b0; m_osid <= '0; m_otag <= '0;
    end else begin
      int k;
      if (lk_valid && (!m_rv || res_ready)) begin
        k = find(lk_rid);
        m_rv   <= 1'b1;
        m_hit  <= (k >= 0);
        m_osid <= (k >= 0) ? m_sid[k] : 6'h0;
        m_otag <= (k >= 0) ? m_tag[k] : 3'h0;
      end else if (res_ready) begin
        m_rv <= 1'b0;
      end
      if (csr_rd_en) m_rd <= reg_val(csr_addr);
      if (csr_wr_en) begin
        k = int'(csr_wdata[4:0]);
        case (csr_addr)
          2'd0: begin
            m_dir <= csr_wdata[16]; m_idx <= csr_wdata[4:0];
            if (csr_wdata[16]) begin
              s_vld <= m_vld[k]; s_tag <= m_tag[k]; s_sid <= m_sid[k];
              s_rid <= m_rid[k]; s_msk <= m_msk[k];
            end else begin
              m_vld[k] <= s_vld; m_tag[k] <= s_tag; m_sid[k] <= s_sid;
              m_rid[k] <= s_rid; m_msk[k] <= s_msk;
            end
          end
          2'd1: begin
            s_vld <= csr_wdata[31]; s_tag <= csr_wdata[10:8]; s_sid <= csr_wdata[5:0];
          end
          2'd2: begin
            s_rid <= csr_wdata[31:16]; s_msk <= csr_wdata[15:0];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (live) begin
      chk("R10 read data", csr_rdata, m_rd);
      chk("R8 result valid", 32'(res_valid), 32'(m_rv));
      chk("R8 request ready", 32'(lk_ready), 32'(!m_rv || res_ready));
      if (m_rv) begin
        chk("R5 hit", 32'(res_hit), 32'(m_hit));
        chk("R6 stream id", 32'(res_sid), 32'(m_osid));
        chk("R5 tag", 32'(res_tag), 32'(m_otag));
        chk("R7 msi value", 32'(res_msi_id), 32'({CID, m_osid}));
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); csr_wr_en = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
    @(negedge clk); csr_rd_en = 1'b1; csr_addr = a;
    @(negedge clk); csr_rd_en = 1'b0;
    chk(req, csr_rdata, exp);
  endtask

  task automatic look(logic [15:0] rid, logic h, logic [5:0] s, logic [2:0] t, string req);
    @(negedge clk); lk_valid = 1'b1; lk_rid = rid;
    @(negedge clk); lk_valid = 1'b0;
    chk(req, {22'h0, res_valid, res_hit, res_tag, res_sid}, {22'h0, 1'b1, h, t, s});
    chk({req, " R7"}, 32'(res_msi_id), 32'({CID, s}));
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; live = 1'b1;
    // R9: reset state
    rd(2'd0, 32'h0, "R9 control after reset");
    rd(2'd1, 32'h0, "R9 attr after reset");
    rd(2'd2, 32'h0, "R9 key after reset");
    look(16'h1234, 1'b0, 6'h0, 3'h0, "R9 R5 empty table misses");
    // R4: field layout and zero bits
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h8000_073F, "R4 attr fields");
    wr(2'd2, 32'h1234_FFFF);
    rd(2'd2, 32'h1234_FFFF, "R4 key fields");
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, 32'h0, "R4 address 3 reads zero");
    rd(2'd1, 32'h8000_073F, "R4 address 3 write ignored");
    // R1 + R3: commit to entry 3, junk in unassigned control bits
    wr(2'd0, 32'hFFFE_FFE3);
    rd(2'd0, 32'h0000_0003, "R1 control readback");
    look(16'h1234, 1'b1, 6'h3F, 3'h7, "R5 exact hit");
    look(16'h1235, 1'b0, 6'h0, 3'h0, "R5 exact mask rejects");
    // R5 partial mask at entry 5
    wr(2'd1, 32'h8000_0205); wr(2'd2, 32'h0100_FF00); wr(2'd0, 32'h5);
    look(16'h01AB, 1'b1, 6'h05, 3'h2, "R5 masked hit");
    look(16'h02AB, 1'b0, 6'h0, 3'h0, "R5 masked miss");
    // R6: catch-all at entry 1 wins
    wr(2'd1, 32'h8000_0109); wr(2'd2, 32'h0); wr(2'd0, 32'h1);
    look(16'h1234, 1'b1, 6'h09, 3'h1, "R6 lower index wins");
    look(16'h01AB, 1'b1, 6'h09, 3'h1, "R6 lower index wins masked");
    // R2: fetch entry 5 into staging
    wr(2'd0, 32'h0001_0005);
    rd(2'd0, 32'h0001_0005, "R1 direction readback");
    rd(2'd1, 32'h8000_0205, "R2 fetched attr");
    rd(2'd2, 32'h0100_FF00, "R2 fetched key");
    // R5: freeing entry 1
    wr(2'd1, 32'h0); wr(2'd2, 32'h0); wr(2'd0, 32'h1);
    look(16'h1234, 1'b1, 6'h3F, 3'h7, "R5 freed entry never matches");
    wr(2'd0, 32'h0001_0001);
    rd(2'd1, 32'h0, "R5 freed entry reads invalid");
    // R10: staging read, not live table
    wr(2'd1, 32'h8000_0001);
    rd(2'd1, 32'h8000_0001, "R10 staging not table");
    look(16'h1234, 1'b1, 6'h3F, 3'h7, "R10 table untouched by staging");
    // R3: commit timing at entry 31
    wr(2'd1, 32'h8000_0011); wr(2'd2, 32'h7777_FFFF);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_addr = 2'd0; csr_wdata = 32'd31;
    lk_valid = 1'b1; lk_rid = 16'h7777;
    @(negedge clk);
    csr_wr_en = 1'b0;
    chk("R3 same-cycle lookup sees old", 32'(res_hit), 32'h0);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R3 next lookup sees new", {26'h0, res_sid}, 32'h11);
    // R8: back-pressure
    @(negedge clk); res_ready = 1'b0; lk_valid = 1'b1; lk_rid = 16'h1234;
    @(negedge clk); lk_rid = 16'h01AB;
    chk("R8 ready low while stalled", 32'(lk_ready), 32'h0);
    chk("R8 first result", 32'(res_sid), 32'h3F);
    @(negedge clk);
    chk("R8 result held", {25'h0, res_valid, res_sid}, {25'h0, 1'b1, 6'h3F});
    res_ready = 1'b1;
    @(negedge clk); lk_valid = 1'b0;
    chk("R8 second result after release", {29'h0, res_tag}, 32'h2);
    // mixed traffic with random back-pressure
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      lk_valid  = ($urandom_range(0, 3) != 0);
      res_ready = ($urandom_range(0, 2) != 0);
      case ($urandom_range(0, 3))
        0: lk_rid = 16'h1234;
        1: lk_rid = {8'h01, 8'($urandom)};
        2: lk_rid = 16'h7777;
        default: lk_rid = 16'($urandom);
      endcase
    end
    @(negedge clk); lk_valid = 1'b0; res_ready = 1'b1;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule